// File: doc/BRIEF.md
# Restoring Decimal Long Divider

This block divides two unsigned packed-decimal integers and returns the whole-number quotient and the remainder, both packed decimal. Each byte nibble holds one decimal digit. All arithmetic stays decimal, so long operands give exact results with no binary rounding.

A single pulse on `start` loads the operands while the block is idle. First the block builds three times the divisor, one digit per cycle. Then it walks the dividend from its most significant digit. For each quotient digit it shifts the next dividend digit into the partial remainder. It subtracts the triple until the result would go negative, and a failed trial is discarded so the last non-negative remainder is kept. It then does the same with the single divisor. The quotient digit is three times the number of accepted triple steps plus the number of accepted single steps. Every trial subtraction passes through one 4-bit decimal digit subtractor, one digit per cycle, from the least significant digit up.

A zero divisor, or any nibble above 9 in either operand, ends the operation at once and raises a flag. The results of a finished operation stay on the outputs until the next accepted start.

Top module: `bcd_divider`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `div_zero` and `bad_digit` are low and `quotient` and `remainder` are zero.
- R2: For valid operands with a nonzero divisor, when `done` is high `quotient` equals the integer part of dividend/divisor and `remainder` equals dividend modulo divisor. Both outputs are packed decimal, with digit k in bits [4k+3:4k], so the least significant digit is in bits [3:0].
- R3: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after an accepted start through the last working cycle, and it is low whenever `done` is high.
- R4: A divisor of zero (with valid digits) makes `done` and `div_zero` high in the cycle after the start, with `quotient` and `remainder` zero and no iteration.
- R5: If any nibble of the dividend or the divisor is above 9, `done` and `bad_digit` go high in the cycle after the start, and `quotient` and `remainder` are zero.
- R6: With W = DIV_DIGITS+1 and per-digit counts a = floor(q/3) and b = q mod 3 for each quotient digit q, `done` rises exactly 1 + W + Σ(1 + W·(a+b+2)) clock edges after the edge that samples `start`. The sum runs over all DVD_DIGITS quotient digits.
- R7: Each quotient digit is found by repeated triple-divisor trials until underflow, then single-divisor trials until underflow. A digit of 8 takes six trials (the worst case), and a digit of 9 takes five. While a digit is being worked, the partial remainder never grows.
- R8: A `start` pulse while `busy` is high is ignored. The running operation's results and timing are unchanged.
- R9: `quotient`, `remainder`, `div_zero` and `bad_digit` hold their values from `done` until the next accepted start.
- R10: Whenever `done` reports a valid division, `remainder` is numerically below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| dividend | input | 4*DVD_DIGITS | Packed-decimal dividend |
| divisor | input | 4*DIV_DIGITS | Packed-decimal divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 4*DVD_DIGITS | Packed-decimal quotient |
| remainder | output | 4*DIV_DIGITS | Packed-decimal remainder |
| div_zero | output | 1 | Last operation had a zero divisor |
| bad_digit | output | 1 | Last operation had a nibble above 9 |

## Verification
Error results (zero divisor, bad nibble) are due one edge after the start, so the bench samples `done` and the flags in the half cycle after that edge. For a real division the bench computes the expected completion edge from the R6 formula, using the quotient digits it derives itself. It counts rising edges from the one that samples `start` and samples each output at the falling edge that follows. A result that arrives early or late fails the latency check, even when the values are right. Hold behaviour is checked several cycles after `done`, before any new start.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TRIPLE,
        S_SHIFT,
        S_SUB3,
        S_SUB1
    } div_state_e;

    function automatic logic nibble_ok(input logic [3:0] nib);
        return nib <= 4'd9;
    endfunction

endpackage

// File: rtl/bcd_digit_sub.sv
// One decimal digit of a - b - borrow_in, with borrow out.
module bcd_digit_sub (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       bin,
    output logic [3:0] diff,
    output logic       bout
);
    logic [4:0] raw;
    logic [4:0] fixed;

    always_comb begin
        raw   = {1'b0, a} - {1'b0, b} - {4'b0, bin};
        fixed = raw + 5'd10;
        bout  = raw[4];
        diff  = raw[4] ? fixed[3:0] : raw[3:0];
    end
endmodule

// File: rtl/bcd_digit_triple.sv
// One decimal digit of 3*d + carry_in, carry in/out in 0..2.
module bcd_digit_triple (
    input  logic [3:0] d,
    input  logic [1:0] cin,
    output logic [3:0] dig,
    output logic [1:0] cout
);
    logic [4:0] sum;

    always_comb begin
        sum = ({1'b0, d} << 1) + {1'b0, d} + {3'b0, cin};
        if (sum >= 5'd20) begin
            cout = 2'd2;
            dig  = 4'(sum - 5'd20);
        end else if (sum >= 5'd10) begin
            cout = 2'd1;
            dig  = 4'(sum - 5'd10);
        end else begin
            cout = 2'd0;
            dig  = sum[3:0];
        end
    end
endmodule

// File: rtl/bcd_divider.sv
module bcd_divider
    import bcd_div_pkg::*;
#(
    parameter int DVD_DIGITS = 4,
    parameter int DIV_DIGITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [4*DVD_DIGITS-1:0] dividend,
    input  logic [4*DIV_DIGITS-1:0] divisor,
    output logic                    busy,
    output logic                    done,
    output logic [4*DVD_DIGITS-1:0] quotient,
    output logic [4*DIV_DIGITS-1:0] remainder,
    output logic                    div_zero,
    output logic                    bad_digit
);
    localparam int W_DIG = DIV_DIGITS + 1;
    localparam int NW    = 4 * DVD_DIGITS;
    localparam int DW    = 4 * DIV_DIGITS;
    localparam int RW    = 4 * W_DIG;
    localparam int CNT_W = $clog2(W_DIG + 1);
    localparam int POS_W = $clog2(DVD_DIGITS + 1);

    typedef struct packed {
        div_state_e       st;
        logic [CNT_W-1:0] dig;
        logic [POS_W-1:0] pos;
        logic [1:0]       cb;
        logic [3:0]       qdig;
        logic [NW-1:0]    dvd;
        logic [RW-1:0]    dvs;
        logic [RW-1:0]    trip;
        logic [RW-1:0]    rem;
        logic [RW-1:0]    trial;
        logic [NW-1:0]    quo;
        logic             done;
        logic             dz;
        logic             bad;
    } regs_t;

    regs_t r_d, r_q;

    // operand screening
    logic [DVD_DIGITS-1:0] dvd_ok;
    logic [DIV_DIGITS-1:0] dvs_ok;
    logic                  in_bad;
    logic                  in_zero;

    for (genvar g = 0; g < DVD_DIGITS; g++) begin : g_dvd_chk
        assign dvd_ok[g] = nibble_ok(dividend[4*g +: 4]);
    end
    for (genvar g = 0; g < DIV_DIGITS; g++) begin : g_dvs_chk
        assign dvs_ok[g] = nibble_ok(divisor[4*g +: 4]);
    end
    assign in_bad  = !(&dvd_ok) || !(&dvs_ok);
    assign in_zero = (divisor == '0);

    // digit-serial datapath
    logic [3:0] a_nib, b_nib, sub_nib, tri_in, tri_nib;
    logic       sub_bout;
    logic [1:0] tri_cout;
    logic       last_dig;

    always_comb begin
        a_nib  = r_q.rem[int'(r_q.dig)*4 +: 4];
        tri_in = r_q.dvs[int'(r_q.dig)*4 +: 4];
        b_nib  = (r_q.st == S_SUB3) ? r_q.trip[int'(r_q.dig)*4 +: 4] : tri_in;
    end
    assign last_dig = (r_q.dig == CNT_W'(W_DIG - 1));

    bcd_digit_sub u_sub (
        .a    (a_nib),
        .b    (b_nib),
        .bin  (r_q.cb[0]),
        .diff (sub_nib),
        .bout (sub_bout)
    );

    bcd_digit_triple u_tri (
        .d    (tri_in),
        .cin  (r_q.cb),
        .dig  (tri_nib),
        .cout (tri_cout)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.quo = '0;
                    r_d.rem = '0;
                    r_d.dz  = in_zero;
                    r_d.bad = in_bad;
                    if (in_bad || in_zero) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st  = S_TRIPLE;
                        r_d.dig = '0;
                        r_d.cb  = '0;
                        r_d.dvd = dividend;
                        r_d.dvs = {4'b0, divisor};
                    end
                end
            end
            S_TRIPLE: begin
                r_d.trip[int'(r_q.dig)*4 +: 4] = tri_nib;
                r_d.cb = tri_cout;
                if (last_dig) begin
                    r_d.st  = S_SHIFT;
                    r_d.dig = '0;
                    r_d.pos = POS_W'(DVD_DIGITS - 1);
                end else begin
                    r_d.dig = r_q.dig + 1'b1;
                end
            end
            S_SHIFT: begin
                r_d.rem  = {r_q.rem[RW-5:0], r_q.dvd[int'(r_q.pos)*4 +: 4]};
                r_d.st   = S_SUB3;
                r_d.dig  = '0;
                r_d.cb   = '0;
                r_d.qdig = '0;
            end
            S_SUB3, S_SUB1: begin
                r_d.trial[int'(r_q.dig)*4 +: 4] = sub_nib;
                r_d.cb = {1'b0, sub_bout};
                if (last_dig) begin
                    r_d.dig = '0;
                    r_d.cb  = '0;
                    if (!sub_bout) begin
                        // trial stayed non-negative: accept it
                        r_d.rem  = r_d.trial;
                        r_d.qdig = r_q.qdig + ((r_q.st == S_SUB3) ? 4'd3 : 4'd1);
                    end else if (r_q.st == S_SUB3) begin
                        r_d.st = S_SUB1;
                    end else begin
                        r_d.quo[int'(r_q.pos)*4 +: 4] = r_q.qdig;
                        if (r_q.pos == '0) begin
                            r_d.st   = S_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.pos = r_q.pos - 1'b1;
                            r_d.st  = S_SHIFT;
                        end
                    end
                end else begin
                    r_d.dig = r_q.dig + 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign quotient  = r_q.quo;
    assign remainder = r_q.rem[DW-1:0];
    assign div_zero  = r_q.dz;
    assign bad_digit = r_q.bad;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0 && !in_bad) |=> (done && div_zero && !busy)); // R4
    AST_BAD_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && in_bad) |=> (done && bad_digit)); // R5
    AST_QDIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.qdig <= 4'd9)); // R7
    AST_REM_NONGROW: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st inside {S_SUB3, S_SUB1}) && ($past(r_q.st) inside {S_SUB3, S_SUB1}))
        |-> (r_q.rem <= $past(r_q.rem))); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> ($stable(quotient) && $stable(remainder))); // R9
    AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !bad_digit) |-> (remainder < r_q.dvs[DW-1:0])); // R10
endmodule

// File: tb/bcd_divider_test.sv
module bcd_divider_test;
    localparam int N  = 4;
    localparam int D  = 2;
    localparam int W  = D + 1;
    localparam int NV = 10;
    localparam int VEC_A [NV] = '{0, 9999, 9999, 1234, 88, 99, 5000, 7, 8765, 100};
    localparam int VEC_B [NV] = '{7, 1, 99, 56, 11, 11, 3, 9, 43, 10};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [4*N-1:0] dividend = '0;
    logic [4*D-1:0] divisor = '0;
    logic           busy, done, div_zero, bad_digit;
    logic [4*N-1:0] quotient;
    logic [4*D-1:0] remainder;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bcd_divider #(.DVD_DIGITS(N), .DIV_DIGITS(D)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_zero(div_zero), .bad_digit(bad_digit)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] to_bcd(input int v);
        logic [31:0] r = '0;
        int x = v;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic int from_bcd(input logic [31:0] b, input int nd);
        int v = 0;
        for (int i = nd - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
        return v;
    endfunction

    function automatic int exp_latency(input int q);
        int lat = 1 + W;
        int x = q;
        for (int i = 0; i < N; i++) begin
            int qd = x % 10;
            lat += 1 + W * (qd / 3 + qd % 3 + 2);
            x = x / 10;
        end
        return lat;
    endfunction

    // Drives one operation; returns edges until done. intrude: start pulse mid-run.
    task automatic run(input logic [4*N-1:0] a, input logic [4*D-1:0] b,
                       input bit intrude, output int lat, output bit busy_ok);
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!done && lat < 3000) begin
            if (!busy) busy_ok = 1'b0;
            if (intrude && lat == 5) begin
                start = 1'b1; dividend = 16'h9999; divisor = 8'h01;
            end else if (intrude && lat == 6) begin
                start = 1'b0; dividend = a; divisor = b;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        if (busy) busy_ok = 1'b0;
        check(lat < 3000, "R3", "watchdog on done", lat, 0);
    endtask

    task automatic full_check(input int a, input int b, input string tag, input bit intrude);
        int lat;
        bit bok;
        int q, r;
        run(to_bcd(a)[4*N-1:0], to_bcd(b)[4*D-1:0], intrude, lat, bok);
        q = from_bcd(32'(quotient), N);
        r = from_bcd(32'(remainder), D);
        check(q == a / b, tag, "quotient", q, a / b);
        check(r == a % b, tag, "remainder", r, a % b);
        check(q * b + r == a, "R2", "q*d+r identity", q * b + r, a);
        check(lat == exp_latency(a / b), "R6", "latency", lat, exp_latency(a / b));
        check(bok, "R3", "busy during run, low at done", bok, 1);
        @(negedge clk);
        check(!done, "R3", "done single pulse", done, 0);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat;
        bit bok;
        logic [4*N-1:0] q_hold;
        logic [4*D-1:0] r_hold;
        repeat (3) @(negedge clk);
        check(!busy && !done && !div_zero && !bad_digit, "R1", "flags in reset",
              {busy, done, div_zero, bad_digit}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(quotient == '0 && remainder == '0, "R1", "results after reset",
              {quotient, remainder}, 0);

        for (int i = 0; i < NV; i++) begin
            full_check(VEC_A[i], VEC_B[i], (VEC_A[i] == 88 || VEC_A[i] == 99) ? "R7" : "R2", 1'b0);
        end

        for (int i = 0; i < 20; i++) begin
            full_check(int'($urandom_range(9999, 0)), int'($urandom_range(99, 1)), "R2", 1'b0);
        end

        // R7: digit 8 worst case (6 trials), digit 9 (5 trials), explicit cycle totals
        run(16'h0088, 8'h11, 1'b0, lat, bok);
        check(lat == 44, "R7", "digit 8 latency", lat, 44);
        run(16'h0099, 8'h11, 1'b0, lat, bok);
        check(lat == 41, "R7", "digit 9 latency", lat, 41);

        // R8: start while busy ignored
        full_check(8765, 43, "R8", 1'b1);

        // R9: hold after done
        q_hold = quotient; r_hold = remainder;
        repeat (4) @(negedge clk);
        check(quotient == q_hold && remainder == r_hold && !done, "R9", "results hold",
              {quotient, remainder}, {q_hold, r_hold});

        // R4: zero divisor
        run(16'h1234, 8'h00, 1'b0, lat, bok);
        check(lat == 1 && div_zero && !bad_digit, "R4", "zero divisor fast flag", lat, 1);
        check(quotient == '0 && remainder == '0, "R4", "zero divisor results", {quotient, remainder}, 0);
        repeat (3) @(negedge clk);
        check(div_zero, "R9", "div_zero holds", div_zero, 1);

        // R5: bad nibble in dividend, then in divisor
        run(16'h12A4, 8'h05, 1'b0, lat, bok);
        check(lat == 1 && bad_digit && !div_zero, "R5", "bad dividend nibble", lat, 1);
        check(quotient == '0 && remainder == '0, "R5", "bad nibble results", {quotient, remainder}, 0);
        run(16'h0042, 8'h0F, 1'b0, lat, bok);
        check(lat == 1 && bad_digit, "R5", "bad divisor nibble", lat, 1);

        // flags clear on the next good start
        full_check(4321, 12, "R2", 1'b0);
        check(!bad_digit && !div_zero, "R9", "flags cleared by new start", {bad_digit, div_zero}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule